// File: doc/BRIEF.md
# Serial Identity CRC-8 Accumulator

This block computes and checks the 8-bit cyclic redundancy code that guards a 64-bit device identity word. The identity is made of an 8-bit family code, a 48-bit serial number and an 8-bit check byte. Bits enter one per clock while a bit-valid strobe is high, least significant bit first. The family code comes first, then the serial number. After the 56 data bits the accumulator holds the check byte. If the 8 check bits are then shifted in as well, a correct identity leaves the accumulator at zero, and a zero flag reports this.

A second path takes the whole 64-bit word at once. On a start strobe it loads the word and clears its own accumulator. It then feeds the word through bit by bit on its own and, after a fixed 64 cycles, pulses done together with a good/bad verdict. The streaming path and the word-check path have separate accumulators and can run at the same time.

Top module: `idcrc_top`

## Requirements
- R1: After reset, crc_o is 8'h00, crc_zero_o is 1, and chk_busy_o and chk_done_o are 0.
- R2: On each clock with bit_vld_i high and crc_clr_i low, the accumulator takes one step. The feedback bit is bit_i XOR accumulator bit 0. The register shifts right by one with a 0 entering bit 7. When the feedback bit is 1, the result is XORed with 8'h8C (the reflected form of x^8+x^5+x^4+1).
- R3: crc_clr_i high sets the accumulator to 8'h00 on the next clock. This takes priority over bit_vld_i, and a bit offered in that cycle is discarded.
- R4: With crc_clr_i and bit_vld_i both low, the accumulator keeps its value.
- R5: After a clear, shifting in 56 bits LSB-first (family code in word bits 7:0, then serial number in word bits 55:8) leaves crc_o equal to the check byte of those 56 bits.
- R6: Shifting in the 8 check-byte bits, LSB first, after those 56 bits leaves crc_o at 8'h00 and crc_zero_o at 1.
- R7: A chk_start_i accepted while idle loads chk_word_i, with bit 0 fed first. chk_done_o is high for exactly one cycle, after the 64th clock edge following the accepting edge.
- R8: chk_good_o is 1 while chk_done_o is high if and only if the full 64-bit word (check byte in bits 63:56) leaves a zero residue.
- R9: chk_start_i while chk_busy_o is high is ignored: the running check keeps its word and its timing.
- R10: chk_busy_o is high from the accepting edge until the edge that raises chk_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_clr_i | input | 1 | Clear streaming accumulator |
| bit_vld_i | input | 1 | Serial bit strobe |
| bit_i | input | 1 | Serial data bit |
| crc_o | output | 8 | Streaming accumulator value |
| crc_zero_o | output | 1 | Streaming accumulator is zero |
| chk_start_i | input | 1 | Start a whole-word check |
| chk_word_i | input | 64 | Identity word to check |
| chk_busy_o | output | 1 | Word check in progress |
| chk_done_o | output | 1 | One-cycle completion pulse |
| chk_good_o | output | 1 | Residue zero, valid with done |

## Verification
On every cycle the assertions check four things: a clear always gives zero, an idle cycle holds the accumulator, done is a single-cycle pulse that only follows a busy cycle, and an accepted start raises busy. Only the bench's scenarios can show that the step rule gives the right check byte over random identities, that appending it gives a zero residue, and that a corrupted word is reported bad. The same holds for the exact 64-cycle latency and for a start arriving mid-check not disturbing the result.

// File: rtl/idcrc_pkg.sv
package idcrc_pkg;
    localparam int CRC_W = 8;

    typedef logic [CRC_W-1:0] crc_t;

    function automatic crc_t crc_step(input crc_t acc, input logic din, input crc_t poly);
        logic fb;
        crc_t nxt;
        fb  = din ^ acc[0];
        nxt = acc >> 1;
        if (fb) nxt = nxt ^ poly;
        return nxt;
    endfunction
endpackage

// File: rtl/idcrc_core.sv
module idcrc_core
    import idcrc_pkg::*;
#(
    parameter crc_t POLY = 8'h8C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic vld_i,
    input  logic din_i,
    output crc_t acc_o,
    output logic zero_o
);
    typedef struct packed {
        crc_t acc;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.acc = '0;
        else if (vld_i)
            st_d.acc = crc_step(st_q.acc, din_i, POLY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign zero_o = (st_q.acc == '0);

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !vld_i) |=> $stable(acc_o));
endmodule

// File: rtl/idcrc_seq.sv
module idcrc_seq
    import idcrc_pkg::*;
#(
    parameter int   ID_W = 64,
    parameter crc_t POLY = 8'h8C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [ID_W-1:0] word_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            good_o
);
    localparam int CNT_W = $clog2(ID_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ID_W - 1);

    typedef struct packed {
        logic [ID_W-1:0]  sh;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    accept;
    logic    res_zero;
    crc_t    res_acc;

    assign accept = start_i && !st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.sh   = word_i;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            st_d.sh  = st_q.sh >> 1;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    idcrc_core #(.POLY(POLY)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .vld_i  (st_q.busy),
        .din_i  (st_q.sh[0]),
        .acc_o  (res_acc),
        .zero_o (res_zero)
    );

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign good_o = st_q.done && res_zero;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));
    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    // R8
    good_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good_o |-> done_o);
endmodule

// File: rtl/idcrc_top.sv
module idcrc_top
    import idcrc_pkg::*;
#(
    parameter int   ID_W = 64,
    parameter crc_t POLY = 8'h8C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            crc_clr_i,
    input  logic            bit_vld_i,
    input  logic            bit_i,
    output logic [7:0]      crc_o,
    output logic            crc_zero_o,
    input  logic            chk_start_i,
    input  logic [ID_W-1:0] chk_word_i,
    output logic            chk_busy_o,
    output logic            chk_done_o,
    output logic            chk_good_o
);
    idcrc_core #(.POLY(POLY)) u_stream (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (crc_clr_i),
        .vld_i  (bit_vld_i),
        .din_i  (bit_i),
        .acc_o  (crc_o),
        .zero_o (crc_zero_o)
    );

    idcrc_seq #(.ID_W(ID_W), .POLY(POLY)) u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (chk_start_i),
        .word_i  (chk_word_i),
        .busy_o  (chk_busy_o),
        .done_o  (chk_done_o),
        .good_o  (chk_good_o)
    );
endmodule

// File: tb/idcrc_top_test.sv
module idcrc_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        crc_clr_i = 0, bit_vld_i = 0, bit_i = 0, chk_start_i = 0;
    logic [63:0] chk_word_i = '0;
    logic [7:0]  crc_o;
    logic        crc_zero_o, chk_busy_o, chk_done_o, chk_good_o;

    int n_cmp = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idcrc_top uut (.*);

    function automatic logic [7:0] m_step(input logic [7:0] a, input logic b);
        logic [7:0] r;
        r = {1'b0, a[7:1]};
        if (b ^ a[0]) r = r ^ 8'h8C;
        return r;
    endfunction

    function automatic logic [7:0] m_crc(input logic [63:0] w, input int n);
        logic [7:0] a = 8'h00;
        for (int i = 0; i < n; i++) a = m_step(a, w[i]);
        return a;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic b);
        bit_vld_i = 1; bit_i = b;
        @(negedge clk);
        bit_vld_i = 0;
    endtask

    task automatic clear_acc();
        crc_clr_i = 1;
        @(negedge clk);
        crc_clr_i = 0;
    endtask

    task automatic run_check(input logic [63:0] w, input bit restart_mid);
        logic exp_good;
        exp_good = (m_crc(w, 64) == 8'h00);
        chk_word_i = w; chk_start_i = 1;
        @(negedge clk);
        chk_start_i = 0;
        check("R10 busy after start", chk_busy_o, 1);
        for (int i = 1; i <= 64; i++) begin
            if (restart_mid && i == 10) begin
                chk_start_i = 1; chk_word_i = ~w;
            end else begin
                chk_start_i = 0;
            end
            @(negedge clk);
            if (i < 64) begin
                if (chk_done_o !== 1'b0 || chk_busy_o !== 1'b1) begin
                    check("R7/R10 early done or busy drop", {chk_done_o, chk_busy_o}, 2'b01);
                end
            end
        end
        chk_start_i = 0;
        check("R7 done at 64", chk_done_o, 1);
        check("R10 busy low at done", chk_busy_o, 0);
        if (restart_mid) check("R9 verdict unchanged", chk_good_o, exp_good);
        else             check("R8 verdict", chk_good_o, exp_good);
        @(negedge clk);
        check("R7 single pulse", chk_done_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expected=finish actual=timeout");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] w;
        logic [7:0]  exp;
        void'($urandom(32'h1D5C_0A17));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 crc", crc_o, 8'h00);
        check("R1 zero", crc_zero_o, 1);
        check("R1 busy/done", {chk_busy_o, chk_done_o}, 2'b00);

        // R2 single step from zero with 1: fb=1 -> 8C
        push(1'b1);
        check("R2 first step", crc_o, 8'h8C);
        exp = 8'h8C;
        for (int i = 0; i < 12; i++) begin
            logic b;
            b = 1'($urandom);
            push(b);
            exp = m_step(exp, b);
            check("R2 step", crc_o, exp);
        end
        // R4 hold
        repeat (5) @(negedge clk);
        check("R4 hold", crc_o, exp);
        // R3 clear beats valid
        crc_clr_i = 1; bit_vld_i = 1; bit_i = 1;
        @(negedge clk);
        crc_clr_i = 0; bit_vld_i = 0;
        check("R3 clear priority", crc_o, 8'h00);
        check("R3 zero flag", crc_zero_o, 1);

        // R5/R6 directed all-zero and all-one ids plus random
        for (int t = 0; t < 24; t++) begin
            if (t == 0)      w = 64'h0;
            else if (t == 1) w = {8'h00, 56'hFF_FFFF_FFFF_FFFF};
            else if (t == 2) w = {8'h00, 48'h0000_0000_1234, 8'h16};
            else             w = {8'h00, 24'($urandom), 32'($urandom)};
            exp = m_crc(w, 56);
            w[63:56] = exp;
            clear_acc();
            for (int i = 0; i < 56; i++) push(w[i]);
            check("R5 check byte", crc_o, exp);
            for (int i = 56; i < 64; i++) push(w[i]);
            check("R6 residue", crc_o, 8'h00);
            check("R6 zero flag", crc_zero_o, 1);
            run_check(w, 1'b0);
            if (t < 8) run_check(w ^ (64'h1 << ($urandom % 64)), 1'b0);
        end
        // R9 restart during busy
        w = {8'h00, 24'($urandom), 32'($urandom)};
        w[63:56] = m_crc(w, 56);
        run_check(w, 1'b1);
        run_check(w ^ 64'h8000_0000_0000_0000, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule